// File: doc/BRIEF.md
# Bit-Slot Ambiguity Resolver

A clock recovered from a split-phase data stream runs at twice the bit rate, so every bit offers two candidate decision instants. Only one of them sits at the true bit centre. This block settles which one by statistics: it is fed one signed soft decision per recovered-clock tick and assigns the ticks in turn to an even slot and an odd slot. For each slot it keeps a hard decision and the size of the soft value.

Once per bit, on the odd-slot tick, the difference in size between the odd and even slots is added to a clamped integrator. A slow leaky average of that integrator picks the winning slot. The hard decision of the winning slot is then presented as the data flag. On the same tick a clock flag toggles and a one-cycle interrupt request is raised for the host that collects the bits. The soft values come from an upstream correlator that is not part of this block.

Top module: `bit_slot_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared. After that edge `clk_flag`, `data_flag` and `host_irq` read 0, `int_metric` and `avg_metric` read 0, and the next tick is taken as an even-slot tick.
- R2: Ticks alternate strictly between the even slot and the odd slot, starting with the even slot. Cycles with `tick_in` low change no state.
- R3: For each tick the hard decision is +1024 when `soft_in` is greater than zero and −1024 otherwise, zero included. The magnitude is |`soft_in`|, with −32768 taken as 32767.
- R4: On an odd-slot tick the integrator gains the odd magnitude minus the stored even magnitude. Even-slot ticks leave `int_metric` and `avg_metric` unchanged.
- R5: The integrator result is clamped to the range −4096 to +4096 inclusive before it is stored.
- R6: On an odd-slot tick the average becomes avg − (avg >>> 5) + (int_new >>> 5), where int_new is the clamped integrator value and both shifts are arithmetic.
- R7: If the new average is negative, the even-slot hard decision is chosen; otherwise the odd-slot decision from the same tick is chosen. `data_flag` becomes 1 when the chosen decision is positive and 0 otherwise, and it changes only on odd-slot ticks.
- R8: `clk_flag` toggles on every odd-slot tick and on no other cycle.
- R9: `host_irq` is high for exactly the one cycle that follows each odd-slot tick.
- R10: All outputs are registered. A tick sampled at edge k is visible on the outputs after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Recovered-clock strobe, one cycle per candidate instant |
| soft_in | input | 16 | Signed soft decision for this tick |
| clk_flag | output | 1 | Bit clock flag, toggles once per bit |
| data_flag | output | 1 | Resolved data bit |
| host_irq | output | 1 | One-cycle request to the host after each bit |
| int_metric | output | 16 | Clamped slot-difference integrator, signed |
| avg_metric | output | 16 | Leaky average of the integrator, signed |

## Verification
On a single odd-slot tick, the clamped integrator update and the slot choice happen in the same cycle, and the choice depends on the average that this very update produces. The sharpest case is an integrator pinned at a rail while the average crosses zero on the same tick, which flips the chosen slot. The bench provokes it by driving runs of bits whose odd-slot magnitude far exceeds the even one, then the reverse, with ticks on back-to-back cycles and with gaps. A behavioural model evaluates the clamp, the average and the selection in order for the same edge, and each output is compared with it on every clock.

// File: rtl/bsr_pkg.sv
// Package: shared word type and slot naming for the bit-slot resolver.
// Assumes 16-bit signed arithmetic throughout the datapath.
package bsr_pkg;
    localparam int DATA_W = 16;

    typedef logic signed [DATA_W-1:0] word_t;

    typedef enum logic {
        SLOT_EVEN = 1'b0,
        SLOT_ODD  = 1'b1
    } slot_e;
endpackage

// File: rtl/bsr_slot_capture.sv
// Slot capture: tracks which candidate slot the next tick belongs to,
// forms the hard decision and saturated magnitude of each soft value,
// and keeps the even-slot pair until the odd tick consumes it.
// Assumes tick_in is a single-cycle strobe; no back-pressure exists.
module bsr_slot_capture
    import bsr_pkg::*;
#(
    parameter int HARD_LEVEL = 1024
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_in,
    input  word_t soft_in,
    output word_t cur_hard,
    output word_t cur_mag,
    output word_t even_hard,
    output word_t even_mag,
    output logic  pair_strobe,
    output logic  slot_is_odd
);
    localparam word_t HARD_P  = word_t'(HARD_LEVEL);
    localparam word_t HARD_N  = -word_t'(HARD_LEVEL);
    localparam word_t MOST_N  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam word_t MOST_P  = {1'b0, {(DATA_W-1){1'b1}}};

    slot_e slot_q;

    // Hard decision and saturated absolute value of the present input.
    always_comb begin
        cur_hard = (soft_in > 0) ? HARD_P : HARD_N;
        if (soft_in == MOST_N)
            cur_mag = MOST_P;
        else if (soft_in < 0)
            cur_mag = -soft_in;
        else
            cur_mag = soft_in;
    end

    assign pair_strobe = tick_in && (slot_q == SLOT_ODD);
    assign slot_is_odd = (slot_q == SLOT_ODD);

    // Slot pointer: flips on every tick so slots strictly alternate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= SLOT_EVEN;
        else if (tick_in)
            slot_q <= (slot_q == SLOT_EVEN) ? SLOT_ODD : SLOT_EVEN;
    end

    // Even-slot store: keeps decision and size until the odd tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_hard <= '0;
            even_mag  <= '0;
        end else if (tick_in && (slot_q == SLOT_EVEN)) begin
            even_hard <= cur_hard;
            even_mag  <= cur_mag;
        end
    end
endmodule

// File: rtl/bsr_integrator.sv
// Integrator and leaky averager: on each odd tick adds the odd-minus-even
// magnitude difference, clamps it to +/-CLAMP_LIM, then leaks the average
// toward the clamped value by 1/2**LEAK_SHIFT. Also exposes the average
// about to be stored so the selector can use it on the same edge.
// Assumes magnitudes are non-negative and CLAMP_LIM fits in DATA_W bits.
module bsr_integrator
    import bsr_pkg::*;
#(
    parameter int CLAMP_LIM  = 4096,
    parameter int LEAK_SHIFT = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pair_strobe,
    input  word_t odd_mag,
    input  word_t even_mag,
    output word_t int_q,
    output word_t avg_q,
    output word_t avg_next
);
    localparam int SUM_W = DATA_W + 2;
    localparam logic signed [SUM_W-1:0] LIM_P = SUM_W'(CLAMP_LIM);
    localparam logic signed [SUM_W-1:0] LIM_N = -LIM_P;

    logic signed [SUM_W-1:0] odd_w, even_w, int_w, sum_w, clip_w;
    logic signed [SUM_W-1:0] avg_w, avg_nx_w;
    word_t                   int_next;

    // Raw sum widened so no intermediate value wraps.
    always_comb begin
        odd_w  = {{2{odd_mag[DATA_W-1]}},  odd_mag};
        even_w = {{2{even_mag[DATA_W-1]}}, even_mag};
        int_w  = {{2{int_q[DATA_W-1]}},    int_q};
        sum_w  = int_w + odd_w - even_w;
    end

    // Rail clamp on the integrator.
    always_comb begin
        if (sum_w > LIM_P)
            clip_w = LIM_P;
        else if (sum_w < LIM_N)
            clip_w = LIM_N;
        else
            clip_w = sum_w;
        int_next = clip_w[DATA_W-1:0];
    end

    // Leaky average: old minus its fraction plus fraction of the new value.
    always_comb begin
        avg_w    = {{2{avg_q[DATA_W-1]}}, avg_q};
        avg_nx_w = avg_w - (avg_w >>> LEAK_SHIFT) + (clip_w >>> LEAK_SHIFT);
        avg_next = avg_nx_w[DATA_W-1:0];
    end

    // State update, once per bit on the odd tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= '0;
            avg_q <= '0;
        end else if (pair_strobe) begin
            int_q <= int_next;
            avg_q <= avg_next;
        end
    end
endmodule

// File: rtl/bsr_status.sv
// Status outputs: on each odd tick picks the even or odd decision by the
// sign of the new average, updates the data flag, toggles the clock flag
// and raises a one-cycle host request.
// Assumes avg_next is the value being stored on the same edge.
module bsr_status
    import bsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pair_strobe,
    input  word_t avg_next,
    input  word_t even_hard,
    input  word_t odd_hard,
    output logic  clk_flag,
    output logic  data_flag,
    output logic  host_irq
);
    word_t chosen;

    // Slot selection: a negative average favours the even slot.
    always_comb begin
        chosen = avg_next[DATA_W-1] ? even_hard : odd_hard;
    end

    // Flag register: clock toggle, resolved bit, one-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_flag  <= 1'b0;
            data_flag <= 1'b0;
            host_irq  <= 1'b0;
        end else begin
            host_irq <= pair_strobe;
            if (pair_strobe) begin
                clk_flag  <= ~clk_flag;
                data_flag <= (chosen > 0);
            end
        end
    end
endmodule

// File: rtl/bit_slot_resolver.sv
// Top: resolves which of two alternating recovered-clock instants is the
// true bit centre and delivers the bit with a clock flag and host request.
// Assumes one tick per candidate instant and a signed soft value per tick.
module bit_slot_resolver
    import bsr_pkg::*;
#(
    parameter int HARD_LEVEL = 1024,
    parameter int CLAMP_LIM  = 4096,
    parameter int LEAK_SHIFT = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_in,
    input  logic signed [DATA_W-1:0] soft_in,
    output logic                     clk_flag,
    output logic                     data_flag,
    output logic                     host_irq,
    output logic signed [DATA_W-1:0] int_metric,
    output logic signed [DATA_W-1:0] avg_metric
);
    word_t cur_hard, cur_mag, even_hard, even_mag;
    word_t int_q, avg_q, avg_next;
    logic  pair_strobe, slot_is_odd;

    bsr_slot_capture #(
        .HARD_LEVEL (HARD_LEVEL)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_in     (tick_in),
        .soft_in     (soft_in),
        .cur_hard    (cur_hard),
        .cur_mag     (cur_mag),
        .even_hard   (even_hard),
        .even_mag    (even_mag),
        .pair_strobe (pair_strobe),
        .slot_is_odd (slot_is_odd)
    );

    bsr_integrator #(
        .CLAMP_LIM  (CLAMP_LIM),
        .LEAK_SHIFT (LEAK_SHIFT)
    ) u_integ (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_strobe (pair_strobe),
        .odd_mag     (cur_mag),
        .even_mag    (even_mag),
        .int_q       (int_q),
        .avg_q       (avg_q),
        .avg_next    (avg_next)
    );

    bsr_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_strobe (pair_strobe),
        .avg_next    (avg_next),
        .even_hard   (even_hard),
        .odd_hard    (cur_hard),
        .clk_flag    (clk_flag),
        .data_flag   (data_flag),
        .host_irq    (host_irq)
    );

    assign int_metric = int_q;
    assign avg_metric = avg_q;
endmodule

// File: rtl/bit_slot_resolver_chk.sv
// Checker: temporal properties of the resolver, bound to the top module.
// Assumes reset is held for at least two edges before release.
module bit_slot_resolver_chk
    import bsr_pkg::*;
#(
    parameter int CLAMP_LIM = 4096
) (
    input logic  clk,
    input logic  rst_n,
    input logic  tick_in,
    input logic  slot_is_odd,
    input logic  pair_strobe,
    input logic  clk_flag,
    input logic  data_flag,
    input logic  host_irq,
    input word_t int_metric,
    input word_t avg_metric
);
    localparam word_t LIM_P = word_t'(CLAMP_LIM);
    localparam word_t LIM_N = -word_t'(CLAMP_LIM);

    assert_slot_alt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && !slot_is_odd) |=> slot_is_odd);

    assert_int_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !host_irq |-> $stable(int_metric));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_metric <= LIM_P) && (int_metric >= LIM_N));

    assert_avg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_irq |-> $stable(avg_metric));

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_irq |-> $stable(data_flag));

    assert_clk_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_flag) |-> host_irq);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(pair_strobe));

    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pair_strobe |=> host_irq);
endmodule

bind bit_slot_resolver bit_slot_resolver_chk #(
    .CLAMP_LIM (CLAMP_LIM)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_in     (tick_in),
    .slot_is_odd (slot_is_odd),
    .pair_strobe (pair_strobe),
    .clk_flag    (clk_flag),
    .data_flag   (data_flag),
    .host_irq    (host_irq),
    .int_metric  (int_metric),
    .avg_metric  (avg_metric)
);

// File: tb/bit_slot_resolver_tb_top.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with every output at each falling edge.
module bit_slot_resolver_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tick_in = 1'b0;
    logic signed [15:0] soft_in = '0;
    logic               clk_flag, data_flag, host_irq;
    logic signed [15:0] int_metric, avg_metric;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // model state
    int m_odd = 0, m_h0 = 0, m_m0 = 0, m_int = 0, m_avg = 0;
    int m_clk = 0, m_dat = 0, m_irq = 0;

    always #2 clk = ~clk;

    bit_slot_resolver dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .soft_in    (soft_in),
        .clk_flag   (clk_flag),
        .data_flag  (data_flag),
        .host_irq   (host_irq),
        .int_metric (int_metric),
        .avg_metric (avg_metric)
    );

    // Reference model: R1 reset, R2 alternation, R3 decision/magnitude,
    // R4..R6 integrate/clamp/average, R7 selection, R8 toggle, R9 request.
    always @(posedge clk) begin
        int s, h, m, sel;
        cycles++;
        if (!rst_n) begin
            m_odd = 0; m_h0 = 0; m_m0 = 0; m_int = 0; m_avg = 0;
            m_clk = 0; m_dat = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (tick_in) begin
                s = soft_in;
                h = (s > 0) ? 1024 : -1024;
                m = (s == -32768) ? 32767 : ((s < 0) ? -s : s);
                if (m_odd == 0) begin
                    m_h0 = h; m_m0 = m; m_odd = 1;
                end else begin
                    m_odd = 0;
                    m_int = m_int + m - m_m0;
                    if (m_int > 4096)  m_int = 4096;
                    if (m_int < -4096) m_int = -4096;
                    m_avg = m_avg - (m_avg >>> 5) + (m_int >>> 5);
                    sel = (m_avg < 0) ? m_h0 : h;
                    m_dat = (sel > 0) ? 1 : 0;
                    m_clk = 1 - m_clk;
                    m_irq = 1;
                end
            end
        end
    end

    task automatic compare();
        n_vec++;
        if (int'(host_irq) != m_irq) begin
            n_fail++;
            $display("FAIL R9 host_irq actual=%0d expected=%0d t=%0t", host_irq, m_irq, $time);
        end
        if (int'(clk_flag) != m_clk) begin
            n_fail++;
            $display("FAIL R8 clk_flag actual=%0d expected=%0d t=%0t", clk_flag, m_clk, $time);
        end
        if (int'(data_flag) != m_dat) begin
            n_fail++;
            $display("FAIL R7 data_flag actual=%0d expected=%0d t=%0t", data_flag, m_dat, $time);
        end
        if (int'(int_metric) != m_int) begin
            n_fail++;
            $display("FAIL R4/R5 int_metric actual=%0d expected=%0d t=%0t", int_metric, m_int, $time);
        end
        if (int'(avg_metric) != m_avg) begin
            n_fail++;
            $display("FAIL R6 avg_metric actual=%0d expected=%0d t=%0t", avg_metric, m_avg, $time);
        end
    endtask

    // One cycle: check outputs of the last edge (R10), then drive the next.
    task automatic step(input bit t, input int s);
        @(negedge clk);
        compare();
        tick_in = t;
        soft_in = 16'(s);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > 60000 && !finished) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=%0d cycles expected=<60000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset held, including a tick during reset that must be ignored
        step(1'b1, 30000);
        step(1'b0, 0);
        step(1'b0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 0);  // R1 reset state compared here
        // R3: positive even, negative odd: int = 3000 - 500
        step(1'b1, 500);
        step(1'b0, 0);  // R2: idle cycles change nothing
        step(1'b0, 0);
        step(1'b1, -3000);
        step(1'b0, 0);
        step(1'b0, 0);
        // R3: zero counts as negative, most-negative saturates
        step(1'b1, 0);
        step(1'b1, -32768);
        step(1'b0, 0);
        step(1'b1, -32768);
        step(1'b1, 0);
        step(1'b0, 0);
        // R5: drive integrator to the positive rail, back-to-back ticks
        for (int i = 0; i < 60; i++) begin
            step(1'b1, (i % 3 == 0) ? -100 : 100);
            step(1'b1, (i % 2 == 0) ? 20000 : -20000);
        end
        // R7: reverse so average crosses zero while integrator is pinned
        for (int i = 0; i < 200; i++) begin
            step(1'b1, (i % 2 == 0) ? 25000 : -25000);
            if (i % 4 == 0) step(1'b0, 7);
            step(1'b1, (i % 5 == 0) ? 50 : -50);
        end
        // R6/R7: mixed random stream with gaps and both polarities
        for (int i = 0; i < 3000; i++) begin
            bit t;
            int v;
            t = ($urandom_range(0, 3) != 0);
            v = int'($urandom_range(0, 65535)) - 32768;
            if (i % 700 < 350 && (i % 2 == 1)) v = v / 8;
            step(t, v);
        end
        step(1'b0, 0);
        step(1'b0, 0);
        finish_run();
    end
endmodule